// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Receiver

This block is the receive half of an asynchronous serial port for shared multidrop buses. A frame is a low start bit, then eight data bits with the least significant bit first, then an optional ninth bit, then a high stop bit. The line is oversampled from a 16x baud tick-enable input, and each bit is decided by a majority vote around its mid-point. By convention a ninth bit of 1 marks an address byte and a ninth bit of 0 marks a data byte.

In nine-bit mode a filter control can be turned on. While it is on, only address frames are delivered, so a slave that has not been addressed never sees the data bytes meant for other nodes. After software recognises its own address, it turns the filter off and then receives every frame that follows. It turns the filter back on at the end of the message. Software compares the addresses. Delivered frames raise a receive flag, which stays set until software clears it. A frame that arrives while the flag is still set is dropped, and an overrun flag is set.

Top module: `mp_uart_rx`

## Requirements
- R1: After a synchronous reset, data_o, bit9_o, irq_o and ovr_o are all 0.
- R2: A frame is a 0 start bit, eight data bits LSB first, a ninth bit only when nine_mode_i is 1, then a stop bit. An accepted frame loads its byte into data_o and sets irq_o.
- R3: Each bit is decided by a two-of-three vote over samples near the middle of its 16 ticks. A disturbance that lasts one tick inside a bit does not change the received value.
- R4: A low level that has returned high before the middle of the start bit is ignored. The receiver goes back to idle and no output changes.
- R5: With nine_mode_i=1 and filt_en_i=1, a frame whose ninth bit is 1 is accepted. bit9_o becomes 1 and irq_o is set.
- R6: With nine_mode_i=1 and filt_en_i=1, a frame whose ninth bit is 0 is suppressed. data_o, bit9_o, irq_o and ovr_o all keep their values.
- R7: With nine_mode_i=1 and filt_en_i=0, every frame is accepted, and bit9_o takes the received ninth bit.
- R8: With nine_mode_i=0, filt_en_i has no effect. Every frame is accepted and bit9_o is loaded with 0.
- R9: An accepted frame that completes while irq_o is 1 is discarded. ovr_o is set, and data_o and bit9_o keep their values.
- R10: A one-cycle pulse on clr_i clears both irq_o and ovr_o.
- R11: filt_en_i may change between frames. Each frame is filtered by the value filt_en_i has when that frame's stop bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick16_i | input | 1 | One-cycle enable at 16 times the baud rate |
| nine_mode_i | input | 1 | 1: frames carry a ninth bit; 0: eight-bit frames |
| filt_en_i | input | 1 | Address filter enable (nine-bit mode only) |
| clr_i | input | 1 | Write-one pulse that clears irq_o and ovr_o |
| data_o | output | 8 | Last accepted byte |
| bit9_o | output | 1 | Ninth bit of the last accepted frame |
| irq_o | output | 1 | Receive flag |
| ovr_o | output | 1 | Overrun flag |

## Verification
Directed frames cover each combination of frame mode, filter setting and ninth-bit value. These cases separate an accepted address frame from a suppressed data byte, and show that the filter has no effect on eight-bit frames. Further directed cases cover a frame completing while the receive flag is still set (overrun), a short low pulse on an idle line (false start), and a one-tick disturbance inside a data bit (majority vote). A random phase then mixes modes, filter settings, payloads and flag clears. It tests that the filter is applied per frame, and that the stored byte changes only when a frame is delivered.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_NINTH = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mpu_rx_sampler.sv
module mpu_rx_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic active_i,
  input  logic rx_i,
  output logic stb_o,
  output logic bit_o
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic [CW-1:0] cnt;
  logic [1:0]    vote;

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      cnt  <= '0;
      vote <= '0;
    end else if (tick_i) begin
      cnt <= (cnt == CW'(OSR-1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(MID-1)) vote[0] <= rx_i;
      if (cnt == CW'(MID))   vote[1] <= rx_i;
    end
  end

  assign stb_o = active_i && tick_i && (cnt == CW'(MID+1));
  assign bit_o = (vote[0] & vote[1]) | (vote[0] & rx_i) | (vote[1] & rx_i);

  // R3
  vote_window_chk: assert property (@(posedge clk) disable iff (rst)
    stb_o |=> !stb_o);
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
  import mpu_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          nine_mode_i,
  input  logic          stb_i,
  input  logic          bit_i,
  output logic          active_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          b9_o
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  rx_state_e     state;
  logic [DW-1:0] sh;
  logic [IW-1:0] idx;
  logic          b9;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sh     <= '0;
      idx    <= '0;
      b9     <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: if (tick_i && !rx_i) begin
          state <= ST_START;
          b9    <= 1'b0;
        end
        ST_START: if (stb_i) begin
          idx   <= '0;
          state <= bit_i ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (stb_i) begin
          sh <= {bit_i, sh[DW-1:1]};
          if (idx == IW'(DW-1)) state <= nine_mode_i ? ST_NINTH : ST_STOP;
          else                  idx   <= idx + 1'b1;
        end
        ST_NINTH: if (stb_i) begin
          b9    <= bit_i;
          state <= ST_STOP;
        end
        ST_STOP: if (stb_i) begin
          done_o <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign active_o = (state != ST_IDLE);
  assign data_o   = sh;
  assign b9_o     = b9;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DW     = 8,
  parameter int OSR    = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_i,
  input  logic          tick16_i,
  input  logic          nine_mode_i,
  input  logic          filt_en_i,
  input  logic          clr_i,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          irq_o,
  output logic          ovr_o
);
  logic          rx_s, active, stb, bitv, frm_done, frm_b9, accept, busy;
  logic [DW-1:0] frm_data;

  mpu_rx_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(rx_i), .q_o(rx_s));

  mpu_rx_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst(rst), .tick_i(tick16_i), .active_i(active),
    .rx_i(rx_s), .stb_o(stb), .bit_o(bitv));

  mpu_rx_frame #(.DW(DW)) u_frame (
    .clk(clk), .rst(rst), .tick_i(tick16_i), .rx_i(rx_s),
    .nine_mode_i(nine_mode_i), .stb_i(stb), .bit_i(bitv),
    .active_o(active), .done_o(frm_done), .data_o(frm_data), .b9_o(frm_b9));

  assign accept = frm_done && (!nine_mode_i || !filt_en_i || frm_b9);
  assign busy   = irq_o && !clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= '0;
      bit9_o <= 1'b0;
      irq_o  <= 1'b0;
      ovr_o  <= 1'b0;
    end else begin
      if (clr_i) begin
        irq_o <= 1'b0;
        ovr_o <= 1'b0;
      end
      if (accept) begin
        if (busy) ovr_o <= 1'b1;
        else begin
          data_o <= frm_data;
          bit9_o <= frm_b9;
          irq_o  <= 1'b1;
        end
      end
    end
  end

  // R6
  filtered_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_done && nine_mode_i && filt_en_i && !frm_b9) |=> ($stable(data_o) && $stable(bit9_o)));
  // R5
  addr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_done && frm_b9 && !irq_o) |=> irq_o);
  // R8
  byte_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !nine_mode_i) |=> (irq_o || ovr_o));
  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_o) |-> $past(irq_o));
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past(clr_i));
endmodule

// File: tb/mp_uart_rx_test.sv
module mp_uart_rx_test;
  logic       clk = 1'b0, rst = 1'b1, rx = 1'b1, tick = 1'b0;
  logic       nine = 1'b1, filt = 1'b1, clr = 1'b0;
  logic [7:0] data_o;
  logic       bit9_o, irq_o, ovr_o;
  int         checks = 0, errors = 0;
  logic [7:0] e_data = '0;
  logic       e_b9 = 0, e_irq = 0, e_ovr = 0;
  bit         done_flag = 0;

  localparam int BITCLK = 64;

  always #2 clk = ~clk;

  mp_uart_rx uut (
    .clk(clk), .rst(rst), .rx_i(rx), .tick16_i(tick),
    .nine_mode_i(nine), .filt_en_i(filt), .clr_i(clr),
    .data_o(data_o), .bit9_o(bit9_o), .irq_o(irq_o), .ovr_o(ovr_o));

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc == 0);
      tc = (tc + 1) % 4;
    end
  end

  function automatic bit qualifies(bit m9, bit f, bit b9);
    return !m9 || !f || b9;
  endfunction

  task automatic check(string req);
    @(negedge clk);
    checks++;
    if ({data_o, bit9_o, irq_o, ovr_o} !== {e_data, e_b9, e_irq, e_ovr}) begin
      errors++;
      $display("FAIL %s: actual data=%h b9=%b irq=%b ovr=%b expected data=%h b9=%b irq=%b ovr=%b",
               req, data_o, bit9_o, irq_o, ovr_o, e_data, e_b9, e_irq, e_ovr);
    end
  endtask

  task automatic hold_bit(bit lvl, bit noisy);
    for (int c = 0; c < BITCLK; c++) begin
      @(negedge clk);
      rx = (noisy && c >= 32 && c < 36) ? ~lvl : lvl;
    end
  endtask

  // noise_idx: data bit index to disturb, -1 for none
  task automatic send(bit m9, logic [7:0] d, bit b9, int noise_idx);
    hold_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) hold_bit(d[i], noise_idx == i);
    if (m9) hold_bit(b9, 1'b0);
    hold_bit(1'b1, 1'b0);
    repeat (16) @(negedge clk);
    if (qualifies(m9, filt, b9)) begin
      if (e_irq) e_ovr = 1'b1;
      else begin
        e_data = d;
        e_b9   = m9 ? b9 : 1'b0;
        e_irq  = 1'b1;
      end
    end
  endtask

  task automatic clear_flags();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    e_irq = 1'b0; e_ovr = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual run still active, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 reset");

    nine = 1; filt = 1;
    send(1, 8'hA5, 1, -1);            check("R5 address accepted");
    clear_flags();                    check("R10 clear");
    send(1, 8'h5A, 0, -1);            check("R6 data suppressed");
    filt = 0;
    send(1, 8'h3C, 0, -1);            check("R7 filter off data");
    send(1, 8'hC3, 1, -1);            check("R9 overrun in nine-bit mode");
    clear_flags();                    check("R10 clear after overrun");
    nine = 0; filt = 1;
    send(0, 8'h81, 0, -1);            check("R8 eight-bit ignores filter");
    send(0, 8'h7E, 0, -1);            check("R9 overrun eight-bit");
    clear_flags();                    check("R10 clear both flags");

    // false start: low for three ticks only
    for (int c = 0; c < 12; c++) begin @(negedge clk); rx = 1'b0; end
    @(negedge clk); rx = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    check("R4 glitch ignored");
    send(0, 8'h96, 0, -1);            check("R4 recovery after glitch");
    clear_flags();

    nine = 1; filt = 0;
    send(1, 8'h69, 1, 3);             check("R3 one-tick disturbance");
    clear_flags();

    for (int n = 0; n < 40; n++) begin
      logic [7:0] d = 8'($urandom);
      bit m9 = 1'($urandom);
      bit b9 = 1'($urandom);
      filt = 1'($urandom);
      nine = m9;
      if ($urandom % 2 == 0) clear_flags();
      send(m9, d, b9, -1);
      check("R11 random frame");
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule